// File: doc/BRIEF.md
# Error Signal Monitor with Timed Escalation

This block watches a single error-signal input driven by a processor and decides whether that processor is healthy. It escalates a fault that persists through three stages. A pin-fault event is raised first. A fail event follows, and it can optionally force the enable-drive output low. A reset request comes last. Time is counted in cycles of a tick input rather than in raw clock cycles, so the same block serves any timebase.

Two modes are selectable. In level mode a low level on the input is the fault itself. In PWM mode the input must toggle with high and low phase durations inside programmable windows. Each out-of-window or overlong phase is a violation, and violations raise an error counter. Good periods lower that counter, and escalation starts once the counter is above a fail threshold. After the reset request, a completion input returns the monitor to normal watching with all counters cleared. Storing the interrupts and sequencing the reset are left to neighbouring blocks.

Top module: `fault_pin_escalator`

## Requirements
- R1: After reset, `pin_evt`, `fail_evt`, `rst_evt` and `rst_req` are 0 and `drv_en` is 1.
- R2: In level mode (`cfg_pwm_mode`=0), the first clock edge that samples `err_in` low raises `pin_evt` for exactly one cycle after that edge. Further low samples in the same low episode raise nothing.
- R3: The escalation condition is a low input in level mode, or error counter > `cfg_fail_thr` in PWM mode. If the condition is first sampled at edge 0 with a tick on every cycle, `fail_evt` is high for the single cycle after edge `cfg_delay1`+1.
- R4: While in the fail or reset stage, `drv_en` is 0 when `cfg_drv_cut`=1. It stays 1 when `cfg_drv_cut`=0.
- R5: Under the same conditions as R3, `rst_evt` pulses for one cycle and `rst_req` rises after edge `cfg_delay1`+`cfg_delay2`+1. `rst_req` holds until `reset_done` is sampled high. After that edge, `rst_req` is 0, `drv_en` is 1, and a still-low or newly low input starts a new episode.
- R6: When the escalation condition is false at an edge, the delay count returns to zero. A low episode of exactly `cfg_delay1`+1 samples therefore never raises `fail_evt`.
- R7: In PWM mode, a phase length is the number of tick samples at one level. A phase that ends outside [min,max] for its level is a violation, and so is a phase that grows past max without an edge (counted once). Each violation pulses `pin_evt`. The first edge after the monitor is enabled only arms the measurement.
- R8: In PWM mode, the error counter rises by 1 per violation and saturates at all ones. It falls by 1, saturating at 0, for each good period: an in-window high phase followed by an in-window low phase. A counter equal to `cfg_fail_thr` does not escalate.
- R9: While `cfg_enable`=0, all counters and stages clear from the next edge. No events are raised, `drv_en` is 1 and `rst_req` is 0.
- R10: Delay counts and phase counts advance only on edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase strobe; counts advance only when high |
| err_in | input | 1 | Error signal from the watched processor (synchronous to clk) |
| cfg_enable | input | 1 | Monitor enable; 0 clears all state |
| cfg_pwm_mode | input | 1 | 0 = level mode, 1 = PWM mode |
| cfg_drv_cut | input | 1 | Force `drv_en` low during fail and reset stages |
| cfg_delay1 | input | DLY_W | First escalation delay in ticks |
| cfg_delay2 | input | DLY_W | Additional delay before the reset stage, in ticks |
| cfg_hi_min | input | PH_W | Minimum high-phase length in ticks |
| cfg_hi_max | input | PH_W | Maximum high-phase length in ticks |
| cfg_lo_min | input | PH_W | Minimum low-phase length in ticks |
| cfg_lo_max | input | PH_W | Maximum low-phase length in ticks |
| cfg_fail_thr | input | CNT_W | Error-counter threshold for PWM escalation |
| reset_done | input | 1 | Completion of the requested warm reset |
| pin_evt | output | 1 | One-cycle pin-fault event |
| fail_evt | output | 1 | One-cycle fail event |
| rst_evt | output | 1 | One-cycle reset event |
| drv_en | output | 1 | Enable-drive control, 1 = allowed |
| rst_req | output | 1 | Warm-reset request, held until `reset_done` |

## Verification
The hardest case to reach from the ports is PWM-mode escalation at an exact cycle. The error counter is internal, and the escalation window opens only once that counter is above the threshold with no good period in between. The stimulus first arms the measurement with clean periods and then toggles the input every cycle, so that every phase is a violation. It takes the second `pin_evt` pulse as the moment the counter passes a threshold of 1, and predicts the fail and reset cycles from that point. A companion scenario adds a good period between violations. A `fail_evt` that appears there shows that the counter is not being lowered.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

   // Escalation stage of the monitor
   typedef enum logic [1:0] {
      STG_WATCH = 2'd0,
      STG_FAIL  = 2'd1,
      STG_RESET = 2'd2
   } stage_e;

endpackage

// File: rtl/fpe_pwm_watch.sv
// Phase-window checker and saturating error counter for PWM mode.
module fpe_pwm_watch #(
   parameter int PH_W  = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             sig,
   input  logic [PH_W-1:0]  hi_min,
   input  logic [PH_W-1:0]  hi_max,
   input  logic [PH_W-1:0]  lo_min,
   input  logic [PH_W-1:0]  lo_max,
   input  logic [CNT_W-1:0] thr,
   output logic             viol,
   output logic             above
);
   localparam int              PCW  = PH_W + 1;
   localparam logic [PCW-1:0]  PMAX = '1;
   localparam logic [CNT_W-1:0] EMAX = '1;

   logic             sig_q;
   logic             armed;
   logic             tmo_seen;
   logic             hi_ok;
   logic [PCW-1:0]   ph_cnt;
   logic [CNT_W-1:0] ecnt;

   logic             edge_s;
   logic             judge;
   logic             in_win;
   logic             tmo;
   logic             good;
   logic [PCW-1:0]   cur_min;
   logic [PCW-1:0]   cur_max;

   assign edge_s  = sig ^ sig_q;
   assign cur_min = sig_q ? {1'b0, hi_min} : {1'b0, lo_min};
   assign cur_max = sig_q ? {1'b0, hi_max} : {1'b0, lo_max};
   assign in_win  = (ph_cnt >= cur_min) && (ph_cnt <= cur_max);
   assign judge   = edge_s && armed && !tmo_seen;
   assign tmo     = !edge_s && !tmo_seen && (ph_cnt > cur_max);
   assign viol    = (judge && !in_win) || tmo;
   assign good    = judge && in_win && !sig_q && hi_ok;
   assign above   = ecnt > thr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_q    <= 1'b0;
         armed    <= 1'b0;
         tmo_seen <= 1'b0;
         hi_ok    <= 1'b0;
         ph_cnt   <= '0;
         ecnt     <= '0;
      end else if (clr) begin
         sig_q    <= 1'b0;
         armed    <= 1'b0;
         tmo_seen <= 1'b0;
         hi_ok    <= 1'b0;
         ph_cnt   <= '0;
         ecnt     <= '0;
      end else begin
         sig_q <= sig;
         if (edge_s) begin
            armed    <= 1'b1;
            tmo_seen <= 1'b0;
            ph_cnt   <= tick ? PCW'(1) : '0;
            hi_ok    <= sig_q ? (judge && in_win) : 1'b0;
         end else begin
            if (tmo) begin
               tmo_seen <= 1'b1;
               hi_ok    <= 1'b0;
            end
            if (tick && (ph_cnt != PMAX))
               ph_cnt <= ph_cnt + PCW'(1);
         end
         if (viol && (ecnt != EMAX))
            ecnt <= ecnt + CNT_W'(1);
         else if (good && (ecnt != '0))
            ecnt <= ecnt - CNT_W'(1);
      end
   end

   // R8: the counter stays at its ceiling under further violations
   p_ecnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (viol && !clr && (ecnt == EMAX)) |=> (ecnt == EMAX));

   // R8: a good period never raises the counter
   p_ecnt_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (good && !clr) |=> (ecnt <= $past(ecnt)));

   // R7: an overlong phase is reported once
   p_tmo_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo && !clr) |=> !tmo);

endmodule

// File: rtl/fpe_escalator.sv
// Shared delay counter that walks watch -> fail -> reset.
module fpe_escalator
   import fpe_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             cond,
   input  logic             ack,
   input  logic [DLY_W-1:0] dly1,
   input  logic [DLY_W-1:0] dly2,
   output stage_e           stage,
   output logic             fail_pulse,
   output logic             rst_pulse
);
   localparam int             CW   = DLY_W + 1;
   localparam logic [CW-1:0]  CMAX = '1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;
   logic [CW-1:0] lim1;
   logic [CW-1:0] lim2;

   assign lim1    = {1'b0, dly1};
   assign lim2    = {1'b0, dly1} + {1'b0, dly2};
   assign cnt_inc = (tick && (cnt != CMAX)) ? cnt + CW'(1) : cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage      <= STG_WATCH;
         cnt        <= '0;
         fail_pulse <= 1'b0;
         rst_pulse  <= 1'b0;
      end else if (clr) begin
         stage      <= STG_WATCH;
         cnt        <= '0;
         fail_pulse <= 1'b0;
         rst_pulse  <= 1'b0;
      end else begin
         fail_pulse <= 1'b0;
         rst_pulse  <= 1'b0;
         case (stage)
            STG_WATCH: begin
               if (!cond) begin
                  cnt <= '0;
               end else begin
                  cnt <= cnt_inc;
                  if (cnt > lim1) begin
                     stage      <= STG_FAIL;
                     fail_pulse <= 1'b1;
                  end
               end
            end
            STG_FAIL: begin
               if (!cond) begin
                  cnt   <= '0;
                  stage <= STG_WATCH;
               end else begin
                  cnt <= cnt_inc;
                  if (cnt > lim2) begin
                     stage     <= STG_RESET;
                     rst_pulse <= 1'b1;
                  end
               end
            end
            STG_RESET: begin
               if (ack) begin
                  cnt   <= '0;
                  stage <= STG_WATCH;
               end
            end
            default: stage <= STG_WATCH;
         endcase
      end
   end

   // R3: a fail pulse follows an edge that saw the condition
   p_fail_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fail_pulse |-> $past(cond));

   // R3: fail pulse lasts one cycle
   p_fail_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fail_pulse |=> !fail_pulse);

   // R5: the reset stage holds until acknowledged
   p_rst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((stage == STG_RESET) && !ack && !clr) |=> (stage == STG_RESET));

endmodule

// File: rtl/fault_pin_escalator.sv
module fault_pin_escalator
   import fpe_pkg::*;
#(
   parameter int DLY_W  = 8,
   parameter int PH_W   = 8,
   parameter int CNT_W  = 4,
   parameter bit PWM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             err_in,
   input  logic             cfg_enable,
   input  logic             cfg_pwm_mode,
   input  logic             cfg_drv_cut,
   input  logic [DLY_W-1:0] cfg_delay1,
   input  logic [DLY_W-1:0] cfg_delay2,
   input  logic [PH_W-1:0]  cfg_hi_min,
   input  logic [PH_W-1:0]  cfg_hi_max,
   input  logic [PH_W-1:0]  cfg_lo_min,
   input  logic [PH_W-1:0]  cfg_lo_max,
   input  logic [CNT_W-1:0] cfg_fail_thr,
   input  logic             reset_done,
   output logic             pin_evt,
   output logic             fail_evt,
   output logic             rst_evt,
   output logic             drv_en,
   output logic             rst_req
);
   // Elaboration-time parameter checks
   if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly
      $error("fault_pin_escalator: DLY_W must be 1..16");
   end
   if (PH_W < 2 || PH_W > 16) begin : g_bad_ph
      $error("fault_pin_escalator: PH_W must be 2..16");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("fault_pin_escalator: CNT_W must be 1..8");
   end

   stage_e stage;
   logic   restart;
   logic   pwm_viol;
   logic   pwm_above;
   logic   lvl_fault;
   logic   fault_q;
   logic   esc_cond;

   assign restart   = (stage == STG_RESET) && reset_done;
   assign lvl_fault = !cfg_pwm_mode && !err_in;

   if (PWM_EN) begin : g_pwm
      logic pwm_clr;
      assign pwm_clr = !cfg_enable || !cfg_pwm_mode || restart;
      fpe_pwm_watch #(
         .PH_W  (PH_W),
         .CNT_W (CNT_W)
      ) pwm_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (pwm_clr),
         .tick   (tick),
         .sig    (err_in),
         .hi_min (cfg_hi_min),
         .hi_max (cfg_hi_max),
         .lo_min (cfg_lo_min),
         .lo_max (cfg_lo_max),
         .thr    (cfg_fail_thr),
         .viol   (pwm_viol),
         .above  (pwm_above)
      );
   end else begin : g_no_pwm
      assign pwm_viol  = 1'b0;
      assign pwm_above = 1'b0;
   end

   assign esc_cond = cfg_pwm_mode ? pwm_above : lvl_fault;

   fpe_escalator #(
      .DLY_W (DLY_W)
   ) esc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!cfg_enable),
      .tick       (tick),
      .cond       (esc_cond),
      .ack        (reset_done),
      .dly1       (cfg_delay1),
      .dly2       (cfg_delay2),
      .stage      (stage),
      .fail_pulse (fail_evt),
      .rst_pulse  (rst_evt)
   );

   // Pin-fault event: level episode start, or each PWM violation
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         pin_evt <= 1'b0;
      end else if (!cfg_enable || restart) begin
         fault_q <= 1'b0;
         pin_evt <= 1'b0;
      end else begin
         fault_q <= lvl_fault;
         pin_evt <= cfg_pwm_mode ? pwm_viol : (lvl_fault && !fault_q);
      end
   end

   assign drv_en  = !(cfg_drv_cut && (stage != STG_WATCH));
   assign rst_req = (stage == STG_RESET);

   // R4: fail with cut enabled drops the enable drive
   p_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_evt && cfg_drv_cut) |-> !drv_en);

   // R9: a disabled monitor is silent one edge later
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (!pin_evt && !fail_evt && !rst_evt && !rst_req && drv_en));

   // R2: level-mode pin event lasts one cycle
   p_pin_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_evt && !cfg_pwm_mode) |=> !pin_evt);

   // R5: a reset event comes with a raised request
   p_rst_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_evt |-> rst_req);

endmodule

// File: tb/fault_pin_escalator_tb_top.sv
`timescale 1ns/1ps
module fault_pin_escalator_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       err_in = 1'b1;
   logic       cfg_enable = 1'b0;
   logic       cfg_pwm_mode = 1'b0;
   logic       cfg_drv_cut = 1'b0;
   logic [7:0] cfg_delay1 = 8'd4;
   logic [7:0] cfg_delay2 = 8'd3;
   logic [7:0] cfg_hi_min = 8'd2;
   logic [7:0] cfg_hi_max = 8'd8;
   logic [7:0] cfg_lo_min = 8'd2;
   logic [7:0] cfg_lo_max = 8'd8;
   logic [3:0] cfg_fail_thr = 4'd1;
   logic       reset_done = 1'b0;
   logic       pin_evt, fail_evt, rst_evt, drv_en, rst_req;

   int checks = 0;
   int errors = 0;
   int npin;
   int nfail;

   always #2 clk = ~clk;

   fault_pin_escalator dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .err_in       (err_in),
      .cfg_enable   (cfg_enable),
      .cfg_pwm_mode (cfg_pwm_mode),
      .cfg_drv_cut  (cfg_drv_cut),
      .cfg_delay1   (cfg_delay1),
      .cfg_delay2   (cfg_delay2),
      .cfg_hi_min   (cfg_hi_min),
      .cfg_hi_max   (cfg_hi_max),
      .cfg_lo_min   (cfg_lo_min),
      .cfg_lo_max   (cfg_lo_max),
      .cfg_fail_thr (cfg_fail_thr),
      .reset_done   (reset_done),
      .pin_evt      (pin_evt),
      .fail_evt     (fail_evt),
      .rst_evt      (rst_evt),
      .drv_en       (drv_en),
      .rst_req      (rst_req)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic fresh(input logic pwm, input logic lvl);
      cfg_enable = 1'b0;
      err_in     = lvl;
      reset_done = 1'b0;
      tick       = 1'b1;
      step();
      cfg_pwm_mode = pwm;
      cfg_enable   = 1'b1;
      step();
   endtask

   task automatic phase(input logic lvl, input int n);
      err_in = lvl;
      for (int i = 0; i < n; i++) begin
         step();
         if (pin_evt)  npin++;
         if (fail_evt) nfail++;
      end
   endtask

   task automatic t_reset_state();
      chk(pin_evt,  0, "R1 pin_evt after reset");
      chk(fail_evt, 0, "R1 fail_evt after reset");
      chk(rst_evt,  0, "R1 rst_evt after reset");
      chk(drv_en,   1, "R1 drv_en after reset");
      chk(rst_req,  0, "R1 rst_req after reset");
   endtask

   task automatic t_level_full();
      int bad = 0;
      cfg_drv_cut = 1'b1; cfg_delay1 = 8'd4; cfg_delay2 = 8'd3;
      fresh(1'b0, 1'b1);
      err_in = 1'b0;
      step();
      chk(pin_evt, 1, "R2 pin_evt on first low sample");
      for (int j = 1; j <= 4; j++) begin
         step();
         if (pin_evt || fail_evt) bad++;
      end
      chk(bad, 0, "R2 R3 no events before delay1 elapses");
      step();
      chk(fail_evt, 1, "R3 fail_evt at edge delay1+1");
      chk(drv_en,   0, "R4 drv_en cut in fail stage");
      bad = 0;
      for (int j = 6; j <= 7; j++) begin
         step();
         if (rst_evt || fail_evt || rst_req) bad++;
      end
      chk(bad, 0, "R5 no reset before delay1+delay2");
      step();
      chk(rst_evt, 1, "R5 rst_evt at edge delay1+delay2+1");
      chk(rst_req, 1, "R5 rst_req raised");
      bad = 0;
      for (int j = 0; j < 5; j++) begin
         step();
         if (!rst_req || rst_evt) bad++;
      end
      chk(bad, 0, "R5 rst_req held until reset_done");
      err_in = 1'b1;
      reset_done = 1'b1;
      step();
      reset_done = 1'b0;
      chk(rst_req, 0, "R5 rst_req released after reset_done");
      chk(drv_en,  1, "R5 drv_en restored after reset_done");
      err_in = 1'b0;
      step();
      chk(pin_evt, 1, "R5 new episode after return to watching");
      err_in = 1'b1;
      step();
   endtask

   task automatic t_level_nocut();
      cfg_drv_cut = 1'b0; cfg_delay1 = 8'd2; cfg_delay2 = 8'd100;
      fresh(1'b0, 1'b1);
      err_in = 1'b0;
      step();
      repeat (2) step();
      step();
      chk(fail_evt, 1, "R3 fail_evt with delay1=2");
      chk(drv_en,   1, "R4 drv_en kept when cut disabled");
      err_in = 1'b1;
      step();
   endtask

   task automatic t_restart();
      cfg_delay1 = 8'd5; cfg_delay2 = 8'd100;
      fresh(1'b0, 1'b1);
      npin = 0; nfail = 0;
      phase(1'b0, 6);
      phase(1'b1, 1);
      phase(1'b0, 6);
      phase(1'b1, 3);
      chk(nfail, 0, "R6 episodes of delay1+1 samples never fail");
      chk(npin,  2, "R2 R6 one pin_evt per low episode");
   endtask

   task automatic t_disable();
      int bad = 0;
      cfg_drv_cut = 1'b1; cfg_delay1 = 8'd2; cfg_delay2 = 8'd100;
      fresh(1'b0, 1'b1);
      err_in = 1'b0;
      repeat (4) step();
      chk(drv_en, 0, "R4 drv_en low before disable");
      cfg_enable = 1'b0;
      step();
      chk(drv_en,  1, "R9 drv_en released when disabled");
      chk(rst_req, 0, "R9 rst_req low when disabled");
      for (int j = 0; j < 10; j++) begin
         step();
         if (pin_evt || fail_evt || rst_evt) bad++;
      end
      chk(bad, 0, "R9 no events while disabled");
      err_in = 1'b1;
      cfg_drv_cut = 1'b0;
   endtask

   task automatic t_tick_gate();
      int n = 0;
      int bad = 0;
      bit fired = 0;
      bit exp_f;
      cfg_delay1 = 8'd3; cfg_delay2 = 8'd200;
      fresh(1'b0, 1'b1);
      err_in = 1'b0;
      for (int k = 0; k < 30; k++) begin
         tick = (k % 2 == 0);
         step();
         exp_f = !fired && (n > 3);
         if (exp_f) fired = 1;
         if (tick) n++;
         if (fail_evt != exp_f) bad++;
      end
      chk(bad,   0, "R10 fail timing counts only tick cycles");
      chk(fired, 1, "R10 fail reached with sparse ticks");
      tick = 1'b1;
      err_in = 1'b1;
      step();
   endtask

   task automatic t_pwm_window();
      cfg_fail_thr = 4'd14; cfg_delay1 = 8'd200;
      fresh(1'b1, 1'b1);
      npin = 0; nfail = 0;
      phase(1'b1, 3);
      phase(1'b0, 4);
      phase(1'b1, 4);
      phase(1'b0, 4);
      phase(1'b1, 30);
      chk(npin, 1, "R7 stuck phase reported once");
      phase(1'b0, 4);
      phase(1'b1, 2);
      phase(1'b0, 4);
      chk(npin, 1, "R7 phase at min length accepted");
      phase(1'b1, 1);
      phase(1'b0, 4);
      chk(npin, 2, "R7 short phase is a violation");
      chk(nfail, 0, "R8 no escalation below threshold");
   endtask

   task automatic t_pwm_decrement();
      cfg_fail_thr = 4'd1; cfg_delay1 = 8'd20; cfg_delay2 = 8'd20;
      fresh(1'b1, 1'b1);
      npin = 0; nfail = 0;
      phase(1'b1, 3);
      phase(1'b0, 4);
      phase(1'b1, 4);
      phase(1'b0, 4);
      phase(1'b1, 1);
      phase(1'b0, 4);
      phase(1'b1, 1);
      phase(1'b0, 4);
      phase(1'b1, 4);
      phase(1'b0, 4);
      for (int i = 0; i < 6; i++) begin
         phase(1'b1, 4);
         phase(1'b0, 4);
      end
      chk(npin,  2, "R7 two violations seen");
      chk(nfail, 0, "R8 good period lowers counter to threshold");
   endtask

   task automatic t_pwm_escalate();
      int c2 = -1;
      int fk = -1;
      int rk = -1;
      cfg_fail_thr = 4'd1; cfg_delay1 = 8'd3; cfg_delay2 = 8'd2;
      cfg_drv_cut = 1'b1;
      fresh(1'b1, 1'b1);
      npin = 0;
      phase(1'b1, 3);
      phase(1'b0, 4);
      phase(1'b1, 4);
      phase(1'b0, 4);
      npin = 0;
      for (int k = 0; k < 40; k++) begin
         err_in = ~err_in;
         step();
         if (pin_evt) begin
            npin++;
            if (npin == 2 && c2 < 0) c2 = k;
         end
         if (fail_evt && fk < 0) fk = k;
         if (rst_evt && rk < 0) rk = k;
      end
      chk(fk, c2 + 5, "R3 R8 PWM fail two edges plus delay1 after counter passes threshold");
      chk(rk, c2 + 7, "R5 R8 PWM reset after delay1+delay2");
      chk(rst_req, 1, "R5 PWM rst_req held");
      chk(drv_en,  0, "R4 drv_en cut in PWM reset stage");
      cfg_drv_cut = 1'b0;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset_state();
      t_level_full();
      t_level_nocut();
      t_restart();
      t_disable();
      t_tick_gate();
      t_pwm_window();
      t_pwm_decrement();
      t_pwm_escalate();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule